// File: doc/BRIEF.md
# Protected Page-Table Address Translator

This block turns a 28-bit byte virtual address into a 26-bit physical address. Pages are 8 KB. The page table sits in physical memory and is indexed directly by the virtual page number (VPN). For each accepted request the block issues one read of the page-table entry (PTE) at `pt_base + 4*VPN` and waits for the memory to return it. It then checks the entry's valid bit. It also checks whether the requester's privilege level may perform the requested read or write. The response carries either the translated address or a fault code.

Protection is one 4-bit code per page. The code names two thresholds: the lowest privilege allowed to read the page and the lowest privilege allowed to write it. Any privilege at or above a threshold has that right, and write access implies read access. As a result, a more privileged level never has less access than a less privileged one. On a successful access the block writes the entry back with its reference bit set, so that a replacement policy elsewhere can use it. Only one translation is in flight at a time, using valid/ready on both the request side and the response side.

Top module: `xlate_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `req_ready` is 1 and `rsp_valid`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: Each accepted request produces exactly one single-cycle `mem_rd_en` pulse, in the cycle after acceptance. Its `mem_addr` equals `(pt_base + 4*VPN) mod 2^26`, where the VPN is `req_vaddr[27:13]`.
- R3: PTE bit fields are: PFN in [12:0], protection code in [16:13], modified in [17], reference in [18], valid in [19]; bits [31:20] are reserved. A permitted access to a valid page responds with `rsp_fault`=0 and `rsp_paddr` = {PFN, `req_vaddr[12:0]`}.
- R4: A PTE with valid bit 0 responds with `rsp_fault`=1 (page fault) and `rsp_paddr`=0.
- R5: Privilege is coded 0=user, 1=supervisor, 2=executive, 3=kernel. Protection codes 0..14 list the threshold pairs (read-min, write-min) with read-min ≤ write-min, each from 0 to 4 (4 = nobody). The list is ordered by read-min and then by write-min: 0=(0,0), 1=(0,1), 2=(0,2), 3=(0,3), 4=(0,4), 5=(1,1) … 14=(4,4). A read is allowed when privilege ≥ read-min, and a write when privilege ≥ write-min. A disallowed access on a valid page responds with `rsp_fault`=2 and `rsp_paddr`=0.
- R6: Protection code 15 is reserved and refuses every access at every privilege level with `rsp_fault`=2.
- R7: On every successful translation, `mem_wr_en` pulses for exactly one cycle. The pulse comes in the cycle that `rsp_valid` rises, at the same `mem_addr` as the read, and `mem_wdata` equals the PTE as read with bit 18 set. All other bits, reserved ones included, are unchanged.
- R8: A faulting translation writes nothing, and the stored PTE is left unchanged.
- R9: `req_ready` is 0 from the acceptance edge until the edge where the response is taken (`rsp_valid` and `rsp_ready`), and it returns to 1 on that edge. While `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold.
- R10: `rsp_valid` rises on the clock edge that samples `mem_rvalid` high while waiting for a PTE. `mem_rvalid` is ignored at any other time and causes no response and no write.
- R11: An invalid PTE reports a page fault even when its protection code would also deny the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_base | input | 26 | Physical byte address of page-table entry 0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 28 | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_priv | input | 2 | Requester privilege level |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 26 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| mem_rd_en | output | 1 | PTE read strobe |
| mem_wr_en | output | 1 | PTE write-back strobe |
| mem_addr | output | 26 | PTE byte address for read and write |
| mem_wdata | output | 32 | PTE value written back |
| mem_rvalid | input | 1 | Read data is on `mem_rdata` |
| mem_rdata | input | 32 | PTE read from memory |

## Verification
Call the request's acceptance edge E0 and the memory's read latency L. The read strobe and PTE address are due on the first cycle after E0. The response and any write-back are due after edge E(L+1), which makes them visible L+2 sample points after E0. The ready flag is due back on the edge that takes the response. The bench drives on the falling edge and samples on the falling edge. It counts falling edges from acceptance and requires the response exactly at count L+2, for L of 1 and of 3. It then checks read strobe, write strobe and data at those fixed sample points and also reads the stored PTE after the write edge.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int NUM_PRIV = 4;
  localparam int PRIV_W   = 2;
  localparam int PROT_W   = 4;
  localparam int THR_W    = 3;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } state_e;

  // Minimum privilege needed for each right; NUM_PRIV means nobody.
  typedef struct packed {
    logic [THR_W-1:0] rd_min;
    logic [THR_W-1:0] wr_min;
  } thresh_t;

  // Codes enumerate monotonic threshold pairs in (rd_min, wr_min) order.
  function automatic thresh_t prot_decode(input logic [PROT_W-1:0] code);
    thresh_t t;
    int idx;
    t.rd_min = THR_W'(NUM_PRIV);
    t.wr_min = THR_W'(NUM_PRIV);
    idx = 0;
    for (int r = 0; r <= NUM_PRIV; r++) begin
      for (int w = r; w <= NUM_PRIV; w++) begin
        if (idx == int'(code)) begin
          t.rd_min = THR_W'(r);
          t.wr_min = THR_W'(w);
        end
        idx++;
      end
    end
    return t;
  endfunction

endpackage

// File: rtl/xlate_rights.sv
module xlate_rights
  import xlate_pkg::*;
(
  input  logic [PROT_W-1:0] prot,
  input  logic [PRIV_W-1:0] priv,
  input  logic              is_write,
  output logic              allow
);

  thresh_t             th;
  logic [NUM_PRIV-1:0] rd_ok;
  logic [NUM_PRIV-1:0] wr_ok;

  assign th = prot_decode(prot);

  for (genvar l = 0; l < NUM_PRIV; l++) begin : g_lvl
    assign rd_ok[l] = (THR_W'(l) >= th.rd_min);
    assign wr_ok[l] = (THR_W'(l) >= th.wr_min);
  end

  assign allow = is_write ? wr_ok[priv] : rd_ok[priv];

endmodule

// File: rtl/xlate_pte_addr.sv
module xlate_pte_addr #(
  parameter int VPN_W     = 15,
  parameter int PA_W      = 26,
  parameter int PTE_BYTES = 4
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  pte_addr
);

  localparam int SH  = $clog2(PTE_BYTES);
  localparam int SCW = VPN_W + SH;

  logic [SCW-1:0] scaled;

  assign scaled   = {vpn, {SH{1'b0}}};
  assign pte_addr = base + PA_W'(scaled);

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int VA_W  = 28,
  parameter int PA_W  = 26,
  parameter int PG_W  = 13,
  parameter int PTE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PG_W-1:0]   req_off,
  input  logic              req_write,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic [PA_W-1:0]   pte_addr,
  output logic              cur_write,
  output logic [PRIV_W-1:0] cur_priv,
  output logic [PROT_W-1:0] cur_prot,
  input  logic              allow,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [PA_W-1:0]   mem_addr,
  output logic [PTE_W-1:0]  mem_wdata,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata
);

  localparam int PFN_W    = PA_W - PG_W;
  localparam int PROT_LSB = PFN_W;
  localparam int MOD_BIT  = PROT_LSB + PROT_W;
  localparam int REF_BIT  = MOD_BIT + 1;
  localparam int VLD_BIT  = REF_BIT + 1;

  state_e          st;
  logic [PG_W-1:0] off_q;
  logic            accept;
  logic            pte_vld;
  logic [PFN_W-1:0] pte_pfn;

  assign accept   = req_valid && req_ready;
  assign pte_vld  = mem_rdata[VLD_BIT];
  assign pte_pfn  = mem_rdata[PFN_W-1:0];
  assign cur_prot = mem_rdata[PROT_LSB +: PROT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      off_q     <= '0;
      cur_write <= 1'b0;
      cur_priv  <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            off_q     <= req_off;
            cur_write <= req_write;
            cur_priv  <= req_priv;
            mem_addr  <= pte_addr;
            mem_rd_en <= 1'b1;
            req_ready <= 1'b0;
            st        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            rsp_valid <= 1'b1;
            st        <= ST_RESP;
            if (!pte_vld) begin
              rsp_fault <= FLT_PAGE;
              rsp_paddr <= '0;
            end else if (!allow) begin
              rsp_fault <= FLT_PROT;
              rsp_paddr <= '0;
            end else begin
              rsp_fault          <= FLT_NONE;
              rsp_paddr          <= {pte_pfn, off_q};
              mem_wr_en          <= 1'b1;
              mem_wdata          <= mem_rdata;
              mem_wdata[REF_BIT] <= 1'b1;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            req_ready <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xlate_top.sv
module xlate_top
  import xlate_pkg::*;
#(
  parameter int VA_W      = 28,
  parameter int PA_W      = 26,
  parameter int PG_W      = 13,
  parameter int PTE_W     = 32,
  parameter int PTE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PA_W-1:0]   pt_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic [PRIV_W-1:0] req_priv,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [PA_W-1:0]   mem_addr,
  output logic [PTE_W-1:0]  mem_wdata,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata
);

  localparam int VPN_W = VA_W - PG_W;

  logic [PA_W-1:0]   pte_addr;
  logic              cur_write;
  logic [PRIV_W-1:0] cur_priv;
  logic [PROT_W-1:0] cur_prot;
  logic              allow;

  xlate_pte_addr #(
    .VPN_W     (VPN_W),
    .PA_W      (PA_W),
    .PTE_BYTES (PTE_BYTES)
  ) u_addr (
    .base     (pt_base),
    .vpn      (req_vaddr[VA_W-1:PG_W]),
    .pte_addr (pte_addr)
  );

  xlate_rights u_rights (
    .prot     (cur_prot),
    .priv     (cur_priv),
    .is_write (cur_write),
    .allow    (allow)
  );

  xlate_ctrl #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .PG_W  (PG_W),
    .PTE_W (PTE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_off    (req_vaddr[PG_W-1:0]),
    .req_write  (req_write),
    .req_priv   (req_priv),
    .pte_addr   (pte_addr),
    .cur_write  (cur_write),
    .cur_priv   (cur_priv),
    .cur_prot   (cur_prot),
    .allow      (allow),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
  );

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int VA_W  = 28,
  parameter int PA_W  = 26,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [PA_W-1:0]  pt_base,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             req_write,
  input logic [1:0]       req_priv,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_fault,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [PA_W-1:0]  mem_addr,
  input logic [PTE_W-1:0] mem_wdata,
  input logic             mem_rvalid,
  input logic [PTE_W-1:0] mem_rdata
);

  logic [PA_W-1:0] rd_addr_q;

  always_ff @(posedge clk) begin
    if (rst) rd_addr_q <= '0;
    else if (mem_rd_en) rd_addr_q <= mem_addr;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_valid && !mem_rd_en && !mem_wr_en));

  // R2
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R2
  rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (!req_ready && !rsp_valid));

  // R4
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  // R5
  fault_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault != 2'd3));

  // R7
  wr_with_ok_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (rsp_valid && rsp_fault == 2'd0 && mem_addr == rd_addr_q));

  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en);

  // R8
  no_wr_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> !mem_wr_en);

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && rsp_valid));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R9
  ready_back_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

endmodule

bind xlate_top xlate_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .PTE_W (PTE_W)
) u_chk (.*);

// File: tb/xlate_top_tb.sv
module xlate_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [25:0] pt_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [27:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_priv = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [25:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_rd_en;
  logic        mem_wr_en;
  logic [25:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  always #2 clk = ~clk;

  xlate_top u_dut (
    .clk(clk), .rst(rst), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  // Memory model: sparse PTE store, read latency lat
  logic [31:0] mem [int];
  int          lat = 1;
  int          cnt = 0;
  logic [25:0] raddr = '0;
  logic        stray = 1'b0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;

  function automatic logic [31:0] mrd(input logic [25:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  assign mem_rvalid = (cnt == 1) || stray;
  assign mem_rdata  = mrd(raddr);

  always @(posedge clk) begin
    if (mem_rd_en) begin
      cnt    <= lat;
      raddr  <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
    if (mem_wr_en) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input bit v, input bit r, input bit m,
                                         input logic [3:0] prot, input logic [12:0] pfn);
    return {12'h000, v, r, m, prot, pfn};
  endfunction

  function automatic bit allowed(input logic [3:0] code, input logic [1:0] p, input bit wr);
    int rmin, wmin;
    case (code)
      4'd0:  begin rmin = 0; wmin = 0; end
      4'd1:  begin rmin = 0; wmin = 1; end
      4'd2:  begin rmin = 0; wmin = 2; end
      4'd3:  begin rmin = 0; wmin = 3; end
      4'd4:  begin rmin = 0; wmin = 4; end
      4'd5:  begin rmin = 1; wmin = 1; end
      4'd6:  begin rmin = 1; wmin = 2; end
      4'd7:  begin rmin = 1; wmin = 3; end
      4'd8:  begin rmin = 1; wmin = 4; end
      4'd9:  begin rmin = 2; wmin = 2; end
      4'd10: begin rmin = 2; wmin = 3; end
      4'd11: begin rmin = 2; wmin = 4; end
      4'd12: begin rmin = 3; wmin = 3; end
      4'd13: begin rmin = 3; wmin = 4; end
      default: begin rmin = 4; wmin = 4; end
    endcase
    return wr ? (int'(p) >= wmin) : (int'(p) >= rmin);
  endfunction

  function automatic logic [25:0] pte_at(input logic [27:0] va);
    return pt_base + {9'd0, va[27:13], 2'b00};
  endfunction

  // One translation with full timing and result checks
  task automatic xlate(input logic [27:0] va, input bit wr, input logic [1:0] p,
                       input int hold, input string tag);
    logic [25:0] a;
    logic [31:0] pte;
    logic [1:0]  ef;
    logic [25:0] epa;
    int n, rd0, wr0;
    a   = pte_at(va);
    pte = mrd(a);
    if (!pte[19])                        ef = 2'd1;
    else if (!allowed(pte[16:13], p, wr)) ef = 2'd2;
    else                                 ef = 2'd0;
    epa = (ef == 2'd0) ? {pte[12:0], va[12:0]} : 26'd0;
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R9 ready before request"}, req_ready, 1);
    req_vaddr = va; req_write = wr; req_priv = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_rd_en == 1'b1 && mem_addr == a, {tag, " R2 pte read addr"}, mem_addr, a);
    check(req_ready == 1'b0, {tag, " R9 busy after accept"}, req_ready, 0);
    n = 1;
    while (!rsp_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n == lat + 2, {tag, " R10 response cycle"}, n, lat + 2);
    check(rsp_fault == ef, {tag, " R3/R4/R5 fault code"}, rsp_fault, ef);
    check(rsp_paddr == epa, {tag, " R3 paddr"}, rsp_paddr, epa);
    check(mem_wr_en == (ef == 2'd0), {tag, " R7/R8 write strobe"}, mem_wr_en, ef == 2'd0);
    if (ef == 2'd0)
      check(mem_wdata == (pte | 32'h0004_0000) && mem_addr == a,
            {tag, " R7 write-back data"}, mem_wdata, pte | 32'h0004_0000);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == epa && rsp_fault == ef && !mem_wr_en,
            {tag, " R9 hold while stalled"}, rsp_paddr, epa);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, {tag, " R9 ready after handshake"}, req_ready, 1);
    check(rd_cnt == rd0 + 1, {tag, " R2 single read"}, rd_cnt - rd0, 1);
    check(wr_cnt == wr0 + ((ef == 2'd0) ? 1 : 0), {tag, " R7/R8 write count"},
          wr_cnt - wr0, (ef == 2'd0) ? 1 : 0);
    if (ef == 2'd0)
      check(mrd(a) == (pte | 32'h0004_0000), {tag, " R7 stored PTE"}, mrd(a), pte | 32'h0004_0000);
    else
      check(mrd(a) == pte, {tag, " R8 PTE untouched"}, mrd(a), pte);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en && !mem_wr_en, "R1 in reset", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en && !mem_wr_en, "R1 after reset", rsp_valid, 0);
  endtask

  task automatic t_basic();
    pt_base = 26'h010_0000;
    mem[int'(pte_at(28'h000_2abc))] = mk_pte(1, 0, 0, 4'd0, 13'h1abc);
    xlate(28'h000_2abc, 1'b0, 2'd0, 0, "basic read R3");
    mem[int'(pte_at(28'h123_4567))] = mk_pte(1, 0, 1, 4'd0, 13'h0042);
    xlate(28'h123_4567, 1'b1, 2'd0, 2, "basic write R3");
  endtask

  task automatic t_page_fault();
    mem[int'(pte_at(28'h0a0_0010))] = mk_pte(0, 0, 0, 4'd0, 13'h0fff);
    xlate(28'h0a0_0010, 1'b0, 2'd3, 0, "invalid R4");
    mem[int'(pte_at(28'h0b0_0020))] = mk_pte(0, 0, 0, 4'd15, 13'h0777);
    xlate(28'h0b0_0020, 1'b1, 2'd0, 0, "invalid+denied R11");
  endtask

  task automatic t_prot();
    mem[int'(pte_at(28'h0c0_1000))] = mk_pte(1, 0, 0, 4'd7, 13'h0123);
    xlate(28'h0c0_1000, 1'b0, 2'd0, 0, "code7 user read R5");
    xlate(28'h0c0_1000, 1'b0, 2'd1, 0, "code7 super read R5");
    xlate(28'h0c0_1000, 1'b1, 2'd2, 0, "code7 exec write R5");
    xlate(28'h0c0_1000, 1'b1, 2'd3, 1, "code7 kernel write R5");
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 4; p++) begin
        for (int w = 0; w < 2; w++) begin
          mem[int'(pte_at(28'h0d0_2000))] = mk_pte(1, 0, 0, 4'(c), 13'h0a5a);
          xlate(28'h0d0_2000 | 28'(c * 8 + p * 2 + w), w[0], 2'(p), 0,
                (c == 15) ? "sweep reserved R6" : "sweep R5");
        end
      end
    end
  endtask

  task automatic t_stray_and_latency();
    logic [31:0] pv;
    @(negedge clk);
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    check(!rsp_valid && req_ready && !mem_wr_en, "R10 stray rvalid in idle ignored", rsp_valid, 0);
    lat = 3;
    pt_base = 26'h3ff_fff0;
    pv = mk_pte(1, 0, 0, 4'd1, 13'h1fff);
    pv[31:20] = 12'ha5c;
    mem[int'(pte_at(28'hfff_ffff))] = pv;
    xlate(28'hfff_ffff, 1'b1, 2'd1, 0, "wrap addr reserved bits R2 R7");
    xlate(28'hfff_ffff, 1'b0, 2'd0, 3, "slow memory R10");
    lat = 1;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_page_fault();
    t_prot();
    t_sweep();
    t_stray_and_latency();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule